// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames on a single line. The line idles high. A frame opens with one low start bit, carries between one and `DATA_W` data bits with the least significant bit first, may carry one parity bit, and closes with a high stop bit. An external 16x oversampling tick paces the receiver. The raw line passes through a two-flop synchronizer. The receiver then locks its bit timing to the tick on which it first sees the line low.

Inside each bit period the receiver takes three samples around the centre, on ticks 7, 8 and 9 of 16. The bit value is the majority of the three, so one corrupted sample cannot change it. If the start bit's vote comes out high, the falling edge is treated as a glitch and the receiver goes back to idle.

When a frame finishes, its data goes into a one-entry holding register along with a frame-error flag and a parity-error flag for that byte. A valid flag marks unread data, and an overrun flag shows that a byte was replaced before it was read. The host acknowledges a byte with a one-cycle read strobe.

Top module: `uart_rx_vote`

## Requirements
- R1: After reset, `rd_valid_o`, `rd_ovr_o`, `rd_frame_err_o` and `rd_par_err_o` are 0 and `rd_data_o` is all zeros.
- R2: The line is checked for low only on tick pulses while the receiver is idle. If the three-sample vote of the start bit comes out high, the receiver returns to idle and no byte is delivered.
- R3: Every bit (start, data, parity, stop) takes the majority of the synchronized line sampled on ticks 7, 8 and 9 of its 16-tick period. Tick 0 is the tick on which the start bit was first seen low. One wrong sample among the three does not change the decided value.
- R4: The number of data bits is `cfg_len_i + 1`. The first data bit received goes to `rd_data_o[0]`, and bits above the configured count read as 0.
- R5: When `cfg_par_en_i` is 1, one parity bit follows the data. `rd_par_err_o` is 1 when the count of ones in data plus parity bit is odd with `cfg_par_odd_i`=0, or even with `cfg_par_odd_i`=1. With `cfg_par_en_i`=0 there is no parity bit and `rd_par_err_o` is 0.
- R6: `rd_frame_err_o` is 1 when the first stop bit votes low, and the byte is still delivered. Any further stop bits are ordinary idle-high time and have no effect.
- R7: One clock after the tick that ends the first stop bit, the byte and its two error flags are loaded and `rd_valid_o` is 1.
- R8: If a frame completes while `rd_valid_o` is 1 and no read is strobed in that cycle, `rd_ovr_o` becomes 1. The new byte and its flags replace the old ones.
- R9: A one-cycle `rd_i` clears `rd_valid_o` and `rd_ovr_o` at the next clock edge. `rd_data_o`, `rd_frame_err_o` and `rd_par_err_o` keep their values.
- R10: While `en_i` is 0 the receiver stays idle and aborts any frame in progress. No byte is delivered and the holding register is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_i | input | 1 | Serial line, asynchronous |
| en_i | input | 1 | Receiver enable |
| cfg_len_i | input | $clog2(DATA_W) | Data bit count minus one |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| rd_i | input | 1 | Read strobe, acknowledges the held byte |
| rd_data_o | output | DATA_W | Held byte |
| rd_valid_o | output | 1 | Unread byte present |
| rd_frame_err_o | output | 1 | Held byte had a low first stop bit |
| rd_par_err_o | output | 1 | Held byte failed its parity check |
| rd_ovr_o | output | 1 | A byte was replaced before it was read |

## Verification
The flags and the byte update one clock after the receiver's own end-of-stop tick. That tick trails the line by two synchronizer clocks plus at most one tick of start alignment. The bench therefore holds the line idle for four more ticks after each stop bit before it samples any result, always on a falling clock edge. The effects of a read show one clock after the strobe, and the bench checks them on the next falling edge. Glitches are driven for exactly one tick period, so exactly one of the three votes sees the wrong level, whatever the phase between the bench and the receiver.

// File: rtl/uart_rx_vote_pkg.sv
package uart_rx_vote_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_rx_vote_sync.sv
module uart_rx_vote_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], d_i};
    end

    // Resets to the idle level of the line.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '1;
        else         stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/uart_rx_vote_sampler.sv
module uart_rx_vote_sampler #(
    parameter int unsigned OVS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic rx_i,
    input  logic restart_i,
    output logic bit_end_o,
    output logic bit_val_o
);
    localparam int unsigned CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [2:0]    smp;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            // The detecting tick counts as tick 0 of the start bit.
            s_d.cnt = CW'(1);
        end else if (tick_i) begin
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
            if (s_q.cnt == MID - 1'b1 || s_q.cnt == MID || s_q.cnt == MID + 1'b1)
                s_d.smp = {s_q.smp[1:0], rx_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{cnt: '0, smp: 3'b111};
        else         s_q <= s_d;
    end

    assign bit_end_o = tick_i && !restart_i && (s_q.cnt == LAST);
    assign bit_val_o = (s_q.smp[0] & s_q.smp[1]) | (s_q.smp[0] & s_q.smp[2]) |
                       (s_q.smp[1] & s_q.smp[2]);

    assert_restart_on_tick_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |-> tick_i);
endmodule

// File: rtl/uart_rx_vote_buf.sv
module uart_rx_vote_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              ld_fe_i,
    input  logic              ld_pe_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              fe_o,
    output logic              pe_o,
    output logic              ovr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              fe;
        logic              pe;
        logic              ovr;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load_i) begin
            h_d.data  = ld_data_i;
            h_d.fe    = ld_fe_i;
            h_d.pe    = ld_pe_i;
            h_d.valid = 1'b1;
            h_d.ovr   = h_q.valid && !rd_i;
        end else if (rd_i) begin
            h_d.valid = 1'b0;
            h_d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) h_q <= '0;
        else         h_q <= h_d;
    end

    assign data_o  = h_q.data;
    assign valid_o = h_q.valid;
    assign fe_o    = h_q.fe;
    assign pe_o    = h_q.pe;
    assign ovr_o   = h_q.ovr;

    assert_load_sets_valid_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> valid_o);
    assert_overrun_flag_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && valid_o && !rd_i) |=> ovr_o);
    assert_ovr_needs_valid_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> !ovr_o);
    assert_read_clears_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !load_i) |=> (!valid_o && !ovr_o && $stable(data_o) && $stable(fe_o)));
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
    import uart_rx_vote_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      tick_i,
    input  logic                      rx_i,
    input  logic                      en_i,
    input  logic [$clog2(DATA_W)-1:0] cfg_len_i,
    input  logic                      cfg_par_en_i,
    input  logic                      cfg_par_odd_i,
    input  logic                      rd_i,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      rd_valid_o,
    output logic                      rd_frame_err_o,
    output logic                      rd_par_err_o,
    output logic                      rd_ovr_o
);
    localparam int unsigned IW = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e         state;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] data;
        logic              pe;
    } fsm_t;

    fsm_t f_d, f_q;
    logic rx_s, bit_end, bit_val, restart, frame_done;

    uart_rx_vote_sync #(.STAGES(SYNC_N)) i_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
    );

    uart_rx_vote_sampler #(.OVS(OVS)) i_sampler (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .rx_i     (rx_s),
        .restart_i(restart),
        .bit_end_o(bit_end),
        .bit_val_o(bit_val)
    );

    always_comb begin
        f_d        = f_q;
        restart    = 1'b0;
        frame_done = 1'b0;
        if (!en_i) begin
            f_d.state = ST_IDLE;
        end else begin
            unique case (f_q.state)
                ST_IDLE: if (tick_i && !rx_s) begin
                    restart   = 1'b1;
                    f_d.state = ST_START;
                end
                ST_START: if (bit_end) begin
                    if (bit_val) begin
                        f_d.state = ST_IDLE;
                    end else begin
                        f_d.state = ST_DATA;
                        f_d.idx   = '0;
                        f_d.data  = '0;
                        f_d.pe    = 1'b0;
                    end
                end
                ST_DATA: if (bit_end) begin
                    f_d.data[f_q.idx] = bit_val;
                    if (f_q.idx == cfg_len_i) f_d.state = cfg_par_en_i ? ST_PAR : ST_STOP;
                    else                      f_d.idx   = f_q.idx + 1'b1;
                end
                ST_PAR: if (bit_end) begin
                    f_d.pe    = (^f_q.data) ^ bit_val ^ cfg_par_odd_i;
                    f_d.state = ST_STOP;
                end
                ST_STOP: if (bit_end) begin
                    frame_done = 1'b1;
                    f_d.state  = ST_IDLE;
                end
                default: f_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '{state: ST_IDLE, idx: '0, data: '0, pe: 1'b0};
        else         f_q <= f_d;
    end

    uart_rx_vote_buf #(.DATA_W(DATA_W)) i_buf (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (frame_done),
        .ld_data_i(f_q.data),
        .ld_fe_i  (!bit_val),
        .ld_pe_i  (f_q.pe),
        .rd_i     (rd_i),
        .data_o   (rd_data_o),
        .valid_o  (rd_valid_o),
        .fe_o     (rd_frame_err_o),
        .pe_o     (rd_par_err_o),
        .ovr_o    (rd_ovr_o)
    );

    assert_off_no_frame_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !frame_done);
    assert_start_from_idle_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart |-> (f_q.state == ST_IDLE && !rx_s));
endmodule

// File: tb/test_uart_rx_vote.sv
`timescale 1ns/1ps
module test_uart_rx_vote;
    logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, en = 1'b0, rd = 1'b0;
    logic par_en = 1'b0, par_odd = 1'b0;
    logic [2:0] len = 3'd7;
    logic [1:0] div_q = '0;
    logic tick;
    logic [7:0] rd_data;
    logic rd_valid, rd_fe, rd_pe, rd_ovr;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) div_q <= div_q + 2'd1;
    assign tick = (div_q == 2'd3);

    uart_rx_vote i_uart_rx_vote (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx), .en_i(en),
        .cfg_len_i(len), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd), .rd_i(rd),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_frame_err_o(rd_fe),
        .rd_par_err_o(rd_pe), .rd_ovr_o(rd_ovr)
    );

    // Packed vector: data, len, parity enable, odd, corrupt parity, stop level.
    localparam int NV = 6;
    localparam logic [14:0] VEC [NV] = '{
        {8'hA5, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h3C, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h3C, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'h5B, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'hC3, 3'd6, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h81, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Holds level v for n ticks; the tick numbered g carries the opposite level.
    task automatic hold(input logic v, input int n, input int g);
        for (int t = 0; t < n; t++) begin
            rx = (t == g) ? ~v : v;
            repeat (4) @(negedge clk);
        end
        rx = v;
    endtask

    // gbit: frame bit that gets a one-tick glitch at tick 8 (0 = start), -1 for none.
    task automatic send(input logic [7:0] d, input logic [2:0] l, input logic pe,
                        input logic po, input logic badp, input logic stp, input int gbit);
        logic p;
        int   k;
        len = l; par_en = pe; par_odd = po;
        p = (^(d & ((9'd2 << l) - 9'd1))) ^ po ^ badp;
        hold(1'b0, 16, (gbit == 0) ? 8 : -1);
        for (int i = 0; i <= int'(l); i++) hold(d[i], 16, (gbit == i + 1) ? 8 : -1);
        k = int'(l) + 2;
        if (pe) begin hold(p, 16, (gbit == k) ? 8 : -1); k++; end
        hold(stp, 16, (gbit == k) ? 8 : -1);
        hold(1'b1, 4, -1);
    endtask

    task automatic read_pulse();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", rd_valid, 0);
        chk("R1 data", rd_data, 0);
        chk("R1 flags", {rd_fe, rd_pe, rd_ovr}, 0);
        en = 1'b1;
        hold(1'b1, 20, -1);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] d, m;
            logic [2:0] l;
            d = VEC[v][14:7]; l = VEC[v][6:4];
            m = 8'((9'd2 << l) - 9'd1);
            send(d, l, VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], -1);
            chk("R7 valid", rd_valid, 1);
            chk("R4 data", rd_data, d & m);
            chk("R5 parity err", rd_pe, VEC[v][3] & VEC[v][1]);
            chk("R6 frame err", rd_fe, !VEC[v][0]);
            chk("R8 no overrun", rd_ovr, 0);
            read_pulse();
            chk("R9 valid clr", rd_valid, 0);
            chk("R9 data kept", rd_data, d & m);
            chk("R9 flags kept", {rd_fe, rd_pe}, {!VEC[v][0], VEC[v][3] & VEC[v][1]});
            hold(1'b1, 20, -1);
        end

        // R2: a short low pulse must not start a frame.
        hold(1'b0, 3, -1);
        hold(1'b1, 200, -1);
        chk("R2 glitch ignored", rd_valid, 0);

        // R3: one bad sample in start, a data bit or the stop bit.
        send(8'hA5, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk("R3 start noise", {rd_valid, rd_data}, {1'b1, 8'hA5});
        read_pulse();
        hold(1'b1, 20, -1);
        send(8'hA5, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 3);
        chk("R3 data noise", {rd_valid, rd_data}, {1'b1, 8'hA5});
        read_pulse();
        hold(1'b1, 20, -1);
        send(8'h5A, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 9);
        chk("R3 stop noise", {rd_valid, rd_fe, rd_data}, {2'b10, 8'h5A});
        read_pulse();
        hold(1'b1, 20, -1);

        // R8: second frame lands before the first is read.
        send(8'h11, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, -1);
        hold(1'b1, 20, -1);
        send(8'h22, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, -1);
        chk("R8 overrun", {rd_valid, rd_ovr}, 2'b11);
        chk("R8 newest data", {rd_data, rd_pe}, {8'h22, 1'b1});
        read_pulse();
        chk("R9 ovr clr", {rd_valid, rd_ovr}, 2'b00);
        hold(1'b1, 20, -1);

        // R10: disabled receiver ignores a full frame.
        en = 1'b0;
        send(8'h55, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        chk("R10 no frame", rd_valid, 0);
        chk("R10 buffer kept", rd_data, 8'h22);
        en = 1'b1;
        hold(1'b1, 20, -1);
        send(8'h66, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        chk("R10 re-enabled", {rd_valid, rd_data}, {1'b1, 8'h66});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not end");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule